// File: doc/BRIEF.md
# Tagged Split-Channel Memory Slave

This block is a memory-backed target on a bus with five separate channels: read request, read data, write request, write data and write response. Each channel has its own valid/ready pair and carries a transaction tag. A read request names a start beat address and a beat count. The slave then returns that many 128-bit beats from its internal memory. Each beat carries the request's tag and a count that falls to zero on the final beat. A write request names a tag and a start address. The write data beats that follow are stored at consecutive locations, and once the final beat is in, the slave answers with a response carrying the same tag.

Five delay registers, loaded through a small register port, control how fast the slave responds at each handshake stage. They set how long each request waits before it is accepted, how long before the first read beat appears, how many empty cycles separate read beats, and how long each write beat waits before it is accepted. This lets a system model vary the slave's throughput. Each channel handles one transaction at a time.

Top module: `tagged_mem_slave`

## Requirements
- R1: After reset, every ready and valid output is low and all five delay registers hold zero.
- R2: A transfer happens only on a rising clock edge with valid and ready both high. The read-request ready goes high D_rreq cycles after the slave, while idle, first sees read-request valid (0 means the same cycle). In the cycle after an accepted read request, the read-request ready is low.
- R3: The first read beat becomes valid after D_first empty cycles following the read-request acceptance edge. After each accepted non-final beat, the next beat becomes valid after D_gap empty cycles.
- R4: For a request with count field N-1, each read beat carries the request tag. The beat count runs N-1, N-2 ... 0, and the beat with count 0 is the last. In the cycle after it is accepted, read-data valid is low.
- R5: While read-data valid is high and ready is low, the valid, data, tag and count of the beat are held unchanged.
- R6: The write-request ready goes high D_wreq cycles after the slave, while idle, first sees write-request valid. Each write-data beat is accepted D_wdat cycles after its valid is first seen during the data phase.
- R7: Write-data ready stays low until the write request has been accepted, so a write-data beat presented before its address waits and is not lost.
- R8: Write beat i (and read beat i) uses memory index (start address + i) modulo MEM_DEPTH. The address is a beat index and wraps at the top of memory.
- R9: A write-data beat whose tag differs from the accepted write request's tag is still consumed, but memory is left unchanged.
- R10: The write response becomes valid in the cycle after the count-0 write beat is accepted. It carries the write request's tag, stays valid with a stable tag until accepted, and goes low after acceptance.
- R11: The register port writes on cfg_we with select 0 = read-request delay, 1 = first read beat delay, 2 = read beat gap, 3 = write-request delay, 4 = write-data beat delay. Each engine takes its delays when it leaves idle, so a write made during a transaction applies from the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Delay register write strobe |
| cfg_sel | input | 3 | Delay register select (0..4) |
| cfg_wdata | input | DLY_W | Delay value in cycles |
| rreq_valid | input | 1 | Read request valid |
| rreq_ready | output | 1 | Read request ready |
| rreq_tag | input | TAG_W | Read request tag |
| rreq_addr | input | AW | Read start beat index |
| rreq_count | input | CNT_W | Read beats minus one |
| rdat_valid | output | 1 | Read beat valid |
| rdat_ready | input | 1 | Read beat ready |
| rdat_tag | output | TAG_W | Tag of the read beat |
| rdat_count | output | CNT_W | Beats remaining after this one |
| rdat_data | output | DATA_W | Read beat data |
| wreq_valid | input | 1 | Write request valid |
| wreq_ready | output | 1 | Write request ready |
| wreq_tag | input | TAG_W | Write request tag |
| wreq_addr | input | AW | Write start beat index |
| wdat_valid | input | 1 | Write beat valid |
| wdat_ready | output | 1 | Write beat ready |
| wdat_tag | input | TAG_W | Write beat tag |
| wdat_count | input | CNT_W | Beats remaining after this one |
| wdat_data | input | DATA_W | Write beat data |
| wrsp_valid | output | 1 | Write response valid |
| wrsp_ready | input | 1 | Write response ready |
| wrsp_tag | output | TAG_W | Write response tag |

## Verification
Ready outputs are combinational from valid and state, so the bench drives each valid just after a falling edge. One time unit later it samples the ready and counts how many such samples show ready low before the accepting edge. That count must equal the programmed delay. Read beats and the write response come from registers and appear in the sample right after the edge that produced them. So the empty cycles before each beat are counted the same way and compared with D_first or D_gap. The response is checked in the sample right after the final write beat's edge. Stall cycles on ready confirm that a waiting beat or response stays unchanged.

// File: rtl/tms_pkg.sv
package tms_pkg;
  localparam int NUM_DLY  = 5;
  localparam int SEL_W    = 3;
  localparam int SEL_RREQ = 0;
  localparam int SEL_RFST = 1;
  localparam int SEL_RGAP = 2;
  localparam int SEL_WREQ = 3;
  localparam int SEL_WDAT = 4;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_ACCEPT,
    RS_PAUSE,
    RS_BEAT
  } rd_state_e;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_ACCEPT,
    WS_DATA,
    WS_RESP
  } wr_state_e;
endpackage

// File: rtl/tms_cfg_regs.sv
module tms_cfg_regs #(
  parameter int DLY_W = 4
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          cfg_we,
  input  logic [tms_pkg::SEL_W-1:0]                     cfg_sel,
  input  logic [DLY_W-1:0]                              cfg_wdata,
  output logic [tms_pkg::NUM_DLY-1:0][DLY_W-1:0]        dly_o
);
  for (genvar i = 0; i < tms_pkg::NUM_DLY; i++) begin : g_reg
    logic [DLY_W-1:0] val_q;
    logic             hit;
    assign hit = cfg_we && (cfg_sel == tms_pkg::SEL_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (hit) val_q <= cfg_wdata;
    end
    assign dly_o[i] = val_q;
  end
endmodule

// File: rtl/tms_mem.sv
module tms_mem #(
  parameter int DATA_W = 128,
  parameter int DEPTH  = 32,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/tms_rd_engine.sv
module tms_rd_engine
  import tms_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 128,
  parameter int DLY_W  = 4,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DLY_W-1:0]  dly_accept,
  input  logic [DLY_W-1:0]  dly_first,
  input  logic [DLY_W-1:0]  dly_gap,
  input  logic              rreq_valid,
  output logic              rreq_ready,
  input  logic [TAG_W-1:0]  rreq_tag,
  input  logic [AW-1:0]     rreq_addr,
  input  logic [CNT_W-1:0]  rreq_count,
  output logic              rdat_valid,
  input  logic              rdat_ready,
  output logic [TAG_W-1:0]  rdat_tag,
  output logic [CNT_W-1:0]  rdat_count,
  output logic [DATA_W-1:0] rdat_data,
  output logic [AW-1:0]     mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata
);
  function automatic logic [AW-1:0] next_index(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  function automatic logic [DLY_W-1:0] wait_load(input logic [DLY_W-1:0] d);
    return d - DLY_W'(1);
  endfunction

  rd_state_e         st_q;
  logic [DLY_W-1:0]  cnt_q;
  logic [DLY_W-1:0]  first_q, gap_q;
  logic [TAG_W-1:0]  tag_q;
  logic [CNT_W-1:0]  left_q;
  logic [AW-1:0]     ptr_q;
  logic [DATA_W-1:0] data_q;

  logic             req_fire, beat_fire, beat_last;
  logic [DLY_W-1:0] eff_first;

  assign req_fire  = rreq_valid && rreq_ready;
  assign beat_fire = rdat_valid && rdat_ready;
  assign beat_last = beat_fire && (left_q == '0);
  assign eff_first = (st_q == RS_IDLE) ? dly_first : first_q;

  always_comb begin
    case (st_q)
      RS_IDLE:   rreq_ready = rreq_valid && (dly_accept == '0);
      RS_ACCEPT: rreq_ready = (cnt_q == '0);
      default:   rreq_ready = 1'b0;
    endcase
  end

  always_comb begin
    case (st_q)
      RS_PAUSE: mem_raddr = ptr_q;
      RS_BEAT:  mem_raddr = next_index(ptr_q);
      default:  mem_raddr = rreq_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RS_IDLE;
      cnt_q   <= '0;
      first_q <= '0;
      gap_q   <= '0;
      tag_q   <= '0;
      left_q  <= '0;
      ptr_q   <= '0;
      data_q  <= '0;
    end else begin
      case (st_q)
        RS_IDLE, RS_ACCEPT: begin
          if (st_q == RS_IDLE && rreq_valid) begin
            first_q <= dly_first;
            gap_q   <= dly_gap;
          end
          if (req_fire) begin
            tag_q  <= rreq_tag;
            left_q <= rreq_count;
            ptr_q  <= rreq_addr;
            if (eff_first == '0) begin
              st_q   <= RS_BEAT;
              data_q <= mem_rdata;
            end else begin
              st_q  <= RS_PAUSE;
              cnt_q <= wait_load(eff_first);
            end
          end else if (st_q == RS_IDLE && rreq_valid) begin
            st_q  <= RS_ACCEPT;
            cnt_q <= wait_load(dly_accept);
          end else if (st_q == RS_ACCEPT && cnt_q != '0) begin
            cnt_q <= cnt_q - DLY_W'(1);
          end
        end
        RS_PAUSE: begin
          if (cnt_q == '0) begin
            st_q   <= RS_BEAT;
            data_q <= mem_rdata;
          end else begin
            cnt_q <= cnt_q - DLY_W'(1);
          end
        end
        default: begin
          if (beat_last) begin
            st_q <= RS_IDLE;
          end else if (beat_fire) begin
            left_q <= left_q - CNT_W'(1);
            ptr_q  <= next_index(ptr_q);
            if (gap_q == '0) begin
              data_q <= mem_rdata;
            end else begin
              st_q  <= RS_PAUSE;
              cnt_q <= wait_load(gap_q);
            end
          end
        end
      endcase
    end
  end

  assign rdat_valid = (st_q == RS_BEAT);
  assign rdat_tag   = tag_q;
  assign rdat_count = left_q;
  assign rdat_data  = data_q;

  a_r2_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !rreq_ready)
    else $error("read request accepted twice in a row");

  a_r5_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rdat_valid && !rdat_ready) |=> (rdat_valid && $stable(rdat_data)
                                     && $stable(rdat_tag) && $stable(rdat_count)))
    else $error("read beat changed while stalled");

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && rdat_count != '0) |=> (rdat_count == $past(rdat_count) - CNT_W'(1)))
    else $error("read beat count did not step down");

  a_r4_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> !rdat_valid)
    else $error("read valid after final beat");
endmodule

// File: rtl/tms_wr_engine.sv
module tms_wr_engine
  import tms_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 128,
  parameter int DLY_W  = 4,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DLY_W-1:0]  dly_accept,
  input  logic [DLY_W-1:0]  dly_beat,
  input  logic              wreq_valid,
  output logic              wreq_ready,
  input  logic [TAG_W-1:0]  wreq_tag,
  input  logic [AW-1:0]     wreq_addr,
  input  logic              wdat_valid,
  output logic              wdat_ready,
  input  logic [TAG_W-1:0]  wdat_tag,
  input  logic [CNT_W-1:0]  wdat_count,
  input  logic [DATA_W-1:0] wdat_data,
  output logic              wrsp_valid,
  input  logic              wrsp_ready,
  output logic [TAG_W-1:0]  wrsp_tag,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [DATA_W-1:0] mem_wdata
);
  function automatic logic [AW-1:0] next_index(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  function automatic logic [DLY_W-1:0] wait_load(input logic [DLY_W-1:0] d);
    return d - DLY_W'(1);
  endfunction

  wr_state_e        st_q;
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] beat_dly_q;
  logic [DLY_W-1:0] dcnt_q;
  logic             dbusy_q;
  logic [TAG_W-1:0] tag_q;
  logic [AW-1:0]    ptr_q;

  logic req_fire, wd_fire, wd_last, rsp_fire, tag_match;

  assign req_fire  = wreq_valid && wreq_ready;
  assign wd_fire   = wdat_valid && wdat_ready;
  assign wd_last   = wd_fire && (wdat_count == '0);
  assign rsp_fire  = wrsp_valid && wrsp_ready;
  assign tag_match = (wdat_tag == tag_q);

  always_comb begin
    case (st_q)
      WS_IDLE:   wreq_ready = wreq_valid && (dly_accept == '0);
      WS_ACCEPT: wreq_ready = (cnt_q == '0);
      default:   wreq_ready = 1'b0;
    endcase
  end

  always_comb begin
    if (st_q != WS_DATA) wdat_ready = 1'b0;
    else if (dbusy_q)    wdat_ready = (dcnt_q == '0);
    else                 wdat_ready = wdat_valid && (beat_dly_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= WS_IDLE;
      cnt_q      <= '0;
      beat_dly_q <= '0;
      dcnt_q     <= '0;
      dbusy_q    <= 1'b0;
      tag_q      <= '0;
      ptr_q      <= '0;
    end else begin
      case (st_q)
        WS_IDLE, WS_ACCEPT: begin
          if (st_q == WS_IDLE && wreq_valid) beat_dly_q <= dly_beat;
          if (req_fire) begin
            st_q    <= WS_DATA;
            tag_q   <= wreq_tag;
            ptr_q   <= wreq_addr;
            dbusy_q <= 1'b0;
          end else if (st_q == WS_IDLE && wreq_valid) begin
            st_q  <= WS_ACCEPT;
            cnt_q <= wait_load(dly_accept);
          end else if (st_q == WS_ACCEPT && cnt_q != '0) begin
            cnt_q <= cnt_q - DLY_W'(1);
          end
        end
        WS_DATA: begin
          if (wd_fire) begin
            dbusy_q <= 1'b0;
            ptr_q   <= next_index(ptr_q);
            if (wd_last) st_q <= WS_RESP;
          end else if (!dbusy_q && wdat_valid) begin
            dbusy_q <= 1'b1;
            dcnt_q  <= wait_load(beat_dly_q);
          end else if (dbusy_q && dcnt_q != '0) begin
            dcnt_q <= dcnt_q - DLY_W'(1);
          end
        end
        default: begin
          if (rsp_fire) st_q <= WS_IDLE;
        end
      endcase
    end
  end

  assign wrsp_valid = (st_q == WS_RESP);
  assign wrsp_tag   = tag_q;
  assign mem_we     = wd_fire && tag_match;
  assign mem_waddr  = ptr_q;
  assign mem_wdata  = wdat_data;

  a_r6_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !wreq_ready)
    else $error("write request accepted twice in a row");

  a_r10_rsp_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrsp_valid) |-> $past(wd_last))
    else $error("write response without final beat");

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsp_valid && !wrsp_ready) |=> (wrsp_valid && $stable(wrsp_tag)))
    else $error("write response changed while stalled");

  a_r7_no_beat_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wreq_ready && !wrsp_valid) |-> !wdat_ready)
    else $error("write beat ready while address pending");
endmodule

// File: rtl/tagged_mem_slave.sv
module tagged_mem_slave
  import tms_pkg::*;
#(
  parameter int TAG_W     = 4,
  parameter int CNT_W     = 4,
  parameter int DATA_W    = 128,
  parameter int DLY_W     = 4,
  parameter int MEM_DEPTH = 32,
  parameter int AW        = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [DLY_W-1:0]  cfg_wdata,
  input  logic              rreq_valid,
  output logic              rreq_ready,
  input  logic [TAG_W-1:0]  rreq_tag,
  input  logic [AW-1:0]     rreq_addr,
  input  logic [CNT_W-1:0]  rreq_count,
  output logic              rdat_valid,
  input  logic              rdat_ready,
  output logic [TAG_W-1:0]  rdat_tag,
  output logic [CNT_W-1:0]  rdat_count,
  output logic [DATA_W-1:0] rdat_data,
  input  logic              wreq_valid,
  output logic              wreq_ready,
  input  logic [TAG_W-1:0]  wreq_tag,
  input  logic [AW-1:0]     wreq_addr,
  input  logic              wdat_valid,
  output logic              wdat_ready,
  input  logic [TAG_W-1:0]  wdat_tag,
  input  logic [CNT_W-1:0]  wdat_count,
  input  logic [DATA_W-1:0] wdat_data,
  output logic              wrsp_valid,
  input  logic              wrsp_ready,
  output logic [TAG_W-1:0]  wrsp_tag
);
  logic [NUM_DLY-1:0][DLY_W-1:0] dly;
  logic              mem_we;
  logic [AW-1:0]     mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  tms_cfg_regs #(.DLY_W(DLY_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dly_o(dly)
  );

  tms_mem #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  tms_rd_engine #(
    .TAG_W(TAG_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .DLY_W(DLY_W), .AW(AW)
  ) u_rd (
    .clk(clk), .rst_n(rst_n),
    .dly_accept(dly[SEL_RREQ]), .dly_first(dly[SEL_RFST]), .dly_gap(dly[SEL_RGAP]),
    .rreq_valid(rreq_valid), .rreq_ready(rreq_ready), .rreq_tag(rreq_tag),
    .rreq_addr(rreq_addr), .rreq_count(rreq_count),
    .rdat_valid(rdat_valid), .rdat_ready(rdat_ready), .rdat_tag(rdat_tag),
    .rdat_count(rdat_count), .rdat_data(rdat_data),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
  );

  tms_wr_engine #(
    .TAG_W(TAG_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .DLY_W(DLY_W), .AW(AW)
  ) u_wr (
    .clk(clk), .rst_n(rst_n),
    .dly_accept(dly[SEL_WREQ]), .dly_beat(dly[SEL_WDAT]),
    .wreq_valid(wreq_valid), .wreq_ready(wreq_ready), .wreq_tag(wreq_tag),
    .wreq_addr(wreq_addr),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_tag(wdat_tag),
    .wdat_count(wdat_count), .wdat_data(wdat_data),
    .wrsp_valid(wrsp_valid), .wrsp_ready(wrsp_ready), .wrsp_tag(wrsp_tag),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  a_r1_quiet_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rdat_valid && !wrsp_valid))
    else $error("outputs active right after reset");
endmodule

// File: tb/tagged_mem_slave_bench.sv
module tagged_mem_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 4, CNT_W = 4, DATA_W = 128, DLY_W = 4, MEM_DEPTH = 32;
  localparam int AW = $clog2(MEM_DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [2:0] cfg_sel = 0; logic [DLY_W-1:0] cfg_wdata = 0;
  logic rreq_valid = 0, rreq_ready; logic [TAG_W-1:0] rreq_tag = 0;
  logic [AW-1:0] rreq_addr = 0; logic [CNT_W-1:0] rreq_count = 0;
  logic rdat_valid, rdat_ready = 0; logic [TAG_W-1:0] rdat_tag;
  logic [CNT_W-1:0] rdat_count; logic [DATA_W-1:0] rdat_data;
  logic wreq_valid = 0, wreq_ready; logic [TAG_W-1:0] wreq_tag = 0; logic [AW-1:0] wreq_addr = 0;
  logic wdat_valid = 0, wdat_ready; logic [TAG_W-1:0] wdat_tag = 0;
  logic [CNT_W-1:0] wdat_count = 0; logic [DATA_W-1:0] wdat_data = 0;
  logic wrsp_valid, wrsp_ready = 0; logic [TAG_W-1:0] wrsp_tag;

  int checks = 0, errors = 0;
  logic [DATA_W-1:0] model [MEM_DEPTH];

  tagged_mem_slave #(.TAG_W(TAG_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .DLY_W(DLY_W),
                     .MEM_DEPTH(MEM_DEPTH)) u_tagged_mem_slave (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rreq_valid(rreq_valid), .rreq_ready(rreq_ready), .rreq_tag(rreq_tag),
    .rreq_addr(rreq_addr), .rreq_count(rreq_count),
    .rdat_valid(rdat_valid), .rdat_ready(rdat_ready), .rdat_tag(rdat_tag),
    .rdat_count(rdat_count), .rdat_data(rdat_data),
    .wreq_valid(wreq_valid), .wreq_ready(wreq_ready), .wreq_tag(wreq_tag),
    .wreq_addr(wreq_addr), .wdat_valid(wdat_valid), .wdat_ready(wdat_ready),
    .wdat_tag(wdat_tag), .wdat_count(wdat_count), .wdat_data(wdat_data),
    .wrsp_valid(wrsp_valid), .wrsp_ready(wrsp_ready), .wrsp_tag(wrsp_tag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] pattern(int seed, int beat);
    logic [DATA_W-1:0] v;
    for (int i = 0; i < DATA_W/32; i++)
      v[i*32 +: 32] = (32'(seed) * 32'h0100_0193) ^ 32'(beat * 131 + i * 7 + 1);
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic set_dly(int sel, int val);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = DLY_W'(val);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Write burst; lead > 0 presents the first data beat before the address.
  task automatic do_write(int tag, int addr, int nbeats, int seed, int btag, int lead,
                          int exp_wreq, int exp_wdat);
    int waits;
    @(negedge clk);
    if (lead > 0) begin
      wdat_valid = 1; wdat_tag = TAG_W'(btag); wdat_count = CNT_W'(nbeats - 1);
      wdat_data = pattern(seed, 0);
      for (int i = 0; i < lead; i++) begin
        #1; check(wdat_ready == 0, "R7", "beat ready before address", DATA_W'(wdat_ready), 0);
        @(negedge clk);
      end
    end
    wreq_valid = 1; wreq_tag = TAG_W'(tag); wreq_addr = AW'(addr);
    waits = 0;
    #1;
    while (!wreq_ready && waits < 40) begin waits++; @(negedge clk); #1; end
    @(negedge clk);
    wreq_valid = 0;
    check(waits == exp_wreq, "R6", "write request wait", DATA_W'(waits), DATA_W'(exp_wreq));
    for (int b = 0; b < nbeats; b++) begin
      wdat_valid = 1; wdat_tag = TAG_W'(btag); wdat_count = CNT_W'(nbeats - 1 - b);
      wdat_data = pattern(seed, b);
      if (btag == tag) model[(addr + b) % MEM_DEPTH] = pattern(seed, b);
      waits = 0;
      #1;
      while (!wdat_ready && waits < 40) begin waits++; @(negedge clk); #1; end
      check(waits == exp_wdat, "R6", "write beat wait", DATA_W'(waits), DATA_W'(exp_wdat));
      @(negedge clk);
    end
    wdat_valid = 0;
    #1;
    check(wrsp_valid == 1, "R10", "response after last beat", DATA_W'(wrsp_valid), 1);
    check(wrsp_tag == TAG_W'(tag), "R10", "response tag", DATA_W'(wrsp_tag), DATA_W'(tag));
    @(negedge clk); #1;
    check(wrsp_valid == 1 && wrsp_tag == TAG_W'(tag), "R10", "response held",
          DATA_W'(wrsp_valid), 1);
    wrsp_ready = 1;
    @(negedge clk);
    wrsp_ready = 0;
    #1;
    check(wrsp_valid == 0, "R10", "response cleared", DATA_W'(wrsp_valid), 0);
  endtask

  // Read burst; chg_gap >= 0 rewrites the gap register after the first beat.
  task automatic do_read(int tag, int addr, int nbeats, int stall, int exp_rreq,
                         int exp_first, int exp_gap, int chg_gap);
    int waits, idle, expv;
    logic [DATA_W-1:0] held;
    @(negedge clk);
    rreq_valid = 1; rreq_tag = TAG_W'(tag); rreq_addr = AW'(addr);
    rreq_count = CNT_W'(nbeats - 1);
    waits = 0;
    #1;
    while (!rreq_ready && waits < 40) begin waits++; @(negedge clk); #1; end
    @(negedge clk);
    rreq_valid = 0;
    check(waits == exp_rreq, "R2", "read request wait", DATA_W'(waits), DATA_W'(exp_rreq));
    #1;
    check(rreq_ready == 0, "R2", "ready low after accept", DATA_W'(rreq_ready), 0);
    for (int b = 0; b < nbeats; b++) begin
      idle = 0;
      while (!rdat_valid && idle < 40) begin idle++; @(negedge clk); #1; end
      expv = (b == 0) ? exp_first : exp_gap;
      check(idle == expv, (b == 0) ? "R3" : "R3/R11", "empty cycles before beat",
            DATA_W'(idle), DATA_W'(expv));
      for (int s = 0; s < stall; s++) begin
        held = rdat_data;
        @(negedge clk); #1;
        check(rdat_valid && rdat_data == held, "R5", "beat held under stall", rdat_data, held);
      end
      check(rdat_tag == TAG_W'(tag), "R4", "beat tag", DATA_W'(rdat_tag), DATA_W'(tag));
      check(rdat_count == CNT_W'(nbeats - 1 - b), "R4", "beat count",
            DATA_W'(rdat_count), DATA_W'(nbeats - 1 - b));
      check(rdat_data == model[(addr + b) % MEM_DEPTH], "R8", "beat data",
            rdat_data, model[(addr + b) % MEM_DEPTH]);
      rdat_ready = 1;
      @(negedge clk);
      rdat_ready = 0;
      if (b == 0 && chg_gap >= 0) begin
        fork
          begin
            cfg_we = 1; cfg_sel = 3'd2; cfg_wdata = DLY_W'(chg_gap);
            @(negedge clk);
            cfg_we = 0;
          end
        join_none
      end
      #1;
    end
    check(rdat_valid == 0, "R4", "valid low after final beat", DATA_W'(rdat_valid), 0);
  endtask

  task automatic t_reset();
    #1;
    check(!rreq_ready && !rdat_valid && !wreq_ready && !wdat_ready && !wrsp_valid,
          "R1", "outputs idle after reset",
          DATA_W'({rreq_ready, rdat_valid, wreq_ready, wdat_ready, wrsp_valid}), 0);
  endtask

  task automatic t_zero_delay();          // R1 zero delay registers, R2, R6
    do_write(3, 4, 4, 1, 3, 0, 0, 0);
    do_read(5, 4, 4, 2, 0, 0, 0, -1);
  endtask

  task automatic t_programmed();          // R11 select codes, R3, R6
    set_dly(0, 2); set_dly(1, 3); set_dly(2, 1); set_dly(3, 1); set_dly(4, 2);
    do_write(6, 12, 3, 2, 6, 0, 1, 2);
    do_read(7, 12, 3, 0, 2, 3, 1, -1);
  endtask

  task automatic t_data_first();          // R7
    do_write(9, 20, 2, 5, 9, 3, 1, 2);
    do_read(1, 20, 2, 1, 2, 3, 1, -1);
  endtask

  task automatic t_snapshot();            // R11
    set_dly(0, 0); set_dly(1, 0); set_dly(2, 0);
    do_read(2, 4, 4, 0, 0, 0, 0, 2);
    do_read(3, 12, 3, 0, 0, 0, 2, -1);
  endtask

  task automatic t_tag_mismatch();        // R9
    do_write(4, 4, 2, 3, 11, 0, 1, 2);
    do_read(12, 4, 2, 0, 0, 0, 2, -1);
  endtask

  task automatic t_wrap();                // R8 and single-beat burst
    set_dly(3, 0); set_dly(4, 0); set_dly(2, 0);
    do_write(8, 30, 4, 4, 8, 0, 0, 0);
    do_read(13, 0, 2, 0, 0, 0, 0, -1);
    do_read(14, 31, 1, 0, 0, 0, 0, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_zero_delay();
    t_programmed();
    t_data_first();
    t_snapshot();
    t_tag_mismatch();
    t_wrap();
    repeat (2) @(negedge clk);
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    report();
    $finish;
  end
endmodule